// File: doc/BRIEF.md
# Gray-Scale Segment Modulator

This block converts one row of 2-bit pixel codes into per-segment on/off drive bits that show four gray shades on a passive matrix panel. Each code points at one of four level registers. Each register holds an intensity index from 0 to 32. The index is split into a whole-frame part and a slot part. Over a four-frame cycle, the segment is driven fully for the whole-frame count of frames. In one further frame it is driven for the slot count of the eight time slots in each common line. It is off for the rest of the cycle.

The surrounding timing logic supplies the frame phase (0..3), a frame-boundary strobe, a line-start strobe, a slot-advance strobe and the AC polarity bit. Level registers can be rewritten at any time, but a new value only reaches the output at the next frame boundary. This avoids a shade change in the middle of a frame. A display-off input drives every segment to the unselected state. The output is inverted together with the polarity bit so that the panel sees no DC.

Top module: `gs_seg_modulator`

## Requirements
- R1: After reset, `seg_out` is all zero. The active levels for codes 0, 1, 2 and 3 are 0, 11, 21 and 32.
- R2: Segment i uses bits [2i+1:2i] of `pix_row` as its code. A code value c selects active level register c.
- R3: Take a level L = 8f + p, with p in 0..7. In frame phase k, the on-state is true on every slot when k < f, true on slots 0..p-1 when k == f, and false otherwise. Summed over phases 0..3, a segment is on for exactly L slots.
- R4: Level 32 is on in every slot of every frame phase.
- R5: A value above 32 written to a level register is stored as 32.
- R6: A write through `lvl_wr_en`/`lvl_wr_sel`/`lvl_wr_data` has no effect on the output until a cycle with `frame_start` high. The new value is used from that edge on.
- R7: Each output bit equals the on-state XOR `fr`.
- R8: While `disp_off` is high, the on-state is forced false, so every `seg_out` bit equals `fr`.
- R9: The slot index becomes 0 on `line_start`, and `line_start` wins over a simultaneous `slot_step`. Otherwise it increases by one on each `slot_step` and holds at 7.
- R10: `seg_out` is registered. It reflects the inputs, slot index and active levels of the previous cycle and does not change between clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_row | input | 2*NSEG | Row of 2-bit pixel codes, segment i at bits [2i+1:2i] |
| lvl_wr_en | input | 1 | Level register write strobe |
| lvl_wr_sel | input | 2 | Which code's level register to write |
| lvl_wr_data | input | LVL_W (6) | Level index to write, clamped to 32 |
| frame_start | input | 1 | Frame boundary: pending levels become active |
| frame_phase | input | PH_W (2) | Position in the four-frame cycle |
| line_start | input | 1 | Restart the slot index at 0 |
| slot_step | input | 1 | Advance the slot index |
| fr | input | 1 | AC polarity bit |
| disp_off | input | 1 | Force all segments to the unselected state |
| seg_out | output | NSEG | Per-segment drive bits |

## Verification
The hardest case to reach from the ports is the accumulated on-time of one segment across a full four-frame cycle. This cannot be read in any single cycle. It only appears when frame phase, slot stepping and the active level all line up for 32 slots. The stimulus sweeps every level value from 0 to 33 through one register, pins segment 0 to that code and walks all four phases. A tally of its on-slots is then compared with the level, while the other segments take random codes and the polarity is random per line. Deferred activation is reached by writing between frame boundaries and driving a line before the boundary. Slot saturation is reached by stepping past the eighth slot.

// File: rtl/gs_mod_pkg.sv
package gs_mod_pkg;
   localparam int GRAY_CODES = 4;
   localparam int CODE_W     = 2;
   typedef logic [CODE_W-1:0] gray_code_t;
endpackage

// File: rtl/gs_level_bank.sv
module gs_level_bank
   import gs_mod_pkg::*;
#(
   parameter int LVL_W    = 6,
   parameter int MAX_LVL  = 32,
   parameter int LVL0_RST = 0,
   parameter int LVL1_RST = 11,
   parameter int LVL2_RST = 21,
   parameter int LVL3_RST = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  gray_code_t                  wr_sel,
   input  logic [LVL_W-1:0]            wr_data,
   input  logic                        frame_start,
   output logic [GRAY_CODES*LVL_W-1:0] act_flat
);
   localparam logic [LVL_W-1:0] MAX_V = LVL_W'(MAX_LVL);

   logic [LVL_W-1:0] wr_clamped;
   assign wr_clamped = (wr_data > MAX_V) ? MAX_V : wr_data;

   for (genvar g = 0; g < GRAY_CODES; g++) begin : g_reg
      localparam int RST_I = (g == 0) ? LVL0_RST : (g == 1) ? LVL1_RST :
                             (g == 2) ? LVL2_RST : LVL3_RST;
      localparam logic [LVL_W-1:0] RST_V = LVL_W'(RST_I);
      logic [LVL_W-1:0] pend_q;
      logic [LVL_W-1:0] act_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= RST_V;
            act_q  <= RST_V;
         end else begin
            if (wr_en && (wr_sel == gray_code_t'(g)))
               pend_q <= wr_clamped;
            if (frame_start)
               act_q <= pend_q;
         end
      end

      assign act_flat[g*LVL_W +: LVL_W] = act_q;
   end
endmodule

// File: rtl/gs_slot_timer.sv
module gs_slot_timer #(
   parameter int SLOTS  = 8,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              slot_step,
   output logic [SLOT_W-1:0] slot_o
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         slot_o <= '0;
      else if (line_start)
         slot_o <= '0;
      else if (slot_step && (slot_o != LAST))
         slot_o <= slot_o + 1'b1;
   end
endmodule

// File: rtl/gs_dot_mod.sv
module gs_dot_mod #(
   parameter int LVL_W  = 6,
   parameter int SLOT_W = 3,
   parameter int PH_W   = 2
) (
   input  logic [LVL_W-1:0]  level,
   input  logic [PH_W-1:0]   phase,
   input  logic [SLOT_W-1:0] slot,
   output logic              on
);
   localparam int F_W = LVL_W - SLOT_W;

   logic [F_W-1:0]    whole_frames;
   logic [SLOT_W-1:0] part_slots;
   logic [F_W-1:0]    phase_ext;

   assign whole_frames = level[LVL_W-1:SLOT_W];
   assign part_slots   = level[SLOT_W-1:0];
   assign phase_ext    = F_W'(phase);

   always_comb begin
      if (phase_ext < whole_frames)
         on = 1'b1;
      else if (phase_ext == whole_frames)
         on = (slot < part_slots);
      else
         on = 1'b0;
   end
endmodule

// File: rtl/gs_seg_modulator.sv
module gs_seg_modulator
   import gs_mod_pkg::*;
#(
   parameter int NSEG     = 128,
   parameter int SLOTS    = 8,
   parameter int FRAMES   = 4,
   parameter int LVL0_RST = 0,
   parameter int LVL1_RST = 11,
   parameter int LVL2_RST = 21,
   parameter int LVL3_RST = 32,
   localparam int SLOT_W  = $clog2(SLOTS),
   localparam int PH_W    = $clog2(FRAMES),
   localparam int LVL_W   = SLOT_W + PH_W + 1,
   localparam int MAX_LVL = SLOTS * FRAMES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*NSEG-1:0]    pix_row,
   input  logic                 lvl_wr_en,
   input  logic [1:0]           lvl_wr_sel,
   input  logic [LVL_W-1:0]     lvl_wr_data,
   input  logic                 frame_start,
   input  logic [PH_W-1:0]      frame_phase,
   input  logic                 line_start,
   input  logic                 slot_step,
   input  logic                 fr,
   input  logic                 disp_off,
   output logic [NSEG-1:0]      seg_out
);
   if (NSEG < 1) begin : g_bad_nseg
      $error("gs_seg_modulator: NSEG must be at least 1");
   end
   if (SLOTS < 2 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("gs_seg_modulator: SLOTS must be a power of two >= 2");
   end
   if (FRAMES < 2 || (1 << PH_W) != FRAMES) begin : g_bad_frames
      $error("gs_seg_modulator: FRAMES must be a power of two >= 2");
   end
   if (LVL0_RST > MAX_LVL || LVL1_RST > MAX_LVL ||
       LVL2_RST > MAX_LVL || LVL3_RST > MAX_LVL) begin : g_bad_rst
      $error("gs_seg_modulator: reset level above maximum");
   end

   logic [GRAY_CODES*LVL_W-1:0] act_flat;
   logic [SLOT_W-1:0]           slot_idx;
   logic [NSEG-1:0]             dot_on;
   logic [NSEG-1:0]             seg_nxt;

   gs_level_bank #(
      .LVL_W(LVL_W), .MAX_LVL(MAX_LVL),
      .LVL0_RST(LVL0_RST), .LVL1_RST(LVL1_RST),
      .LVL2_RST(LVL2_RST), .LVL3_RST(LVL3_RST)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(lvl_wr_en), .wr_sel(lvl_wr_sel), .wr_data(lvl_wr_data),
      .frame_start(frame_start), .act_flat(act_flat)
   );

   gs_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .line_start(line_start), .slot_step(slot_step), .slot_o(slot_idx)
   );

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      gray_code_t       code;
      logic [LVL_W-1:0] lvl;
      assign code = pix_row[2*i +: 2];
      assign lvl  = act_flat[code*LVL_W +: LVL_W];

      gs_dot_mod #(.LVL_W(LVL_W), .SLOT_W(SLOT_W), .PH_W(PH_W)) u_dot (
         .level(lvl), .phase(frame_phase), .slot(slot_idx), .on(dot_on[i])
      );

      assign seg_nxt[i] = (dot_on[i] & ~disp_off) ^ fr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         seg_out <= '0;
      else
         seg_out <= seg_nxt;
   end
endmodule

// File: rtl/gs_seg_modulator_chk.sv
module gs_seg_modulator_chk #(
   parameter int NSEG   = 128,
   parameter int SLOT_W = 3,
   parameter int LVL_W  = 6,
   parameter int MAX_LVL = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fr,
   input logic              disp_off,
   input logic              line_start,
   input logic              slot_step,
   input logic              frame_start,
   input logic [SLOT_W-1:0] slot_idx,
   input logic [4*LVL_W-1:0] act_flat,
   input logic [NSEG-1:0]   seg_out
);
   localparam logic [SLOT_W-1:0] LAST = '1;

   // R8 / R7: display-off gives the polarity bit on every segment
   a_r8_blank_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      disp_off |=> (seg_out == {NSEG{$past(fr)}}));

   // R9: line start restarts the slot index
   a_r9_slot_restart: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (slot_idx == '0));

   // R9: slot index holds at the last slot
   a_r9_slot_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_start && slot_idx == LAST) |=> (slot_idx == LAST));

   // R9: slot index moves by one only on a step
   a_r9_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_start && !slot_step) |=> $stable(slot_idx));

   // R6: active levels change only at a frame boundary
   a_r6_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_flat));

   // R5: no active level above the maximum
   for (genvar g = 0; g < 4; g++) begin : g_lvl
      a_r5_level_clamped: assert property (@(posedge clk) disable iff (!rst_n)
         act_flat[g*LVL_W +: LVL_W] <= LVL_W'(MAX_LVL));
   end
endmodule

bind gs_seg_modulator gs_seg_modulator_chk #(
   .NSEG(NSEG), .SLOT_W(SLOT_W), .LVL_W(LVL_W), .MAX_LVL(MAX_LVL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fr(fr), .disp_off(disp_off),
   .line_start(line_start), .slot_step(slot_step), .frame_start(frame_start),
   .slot_idx(slot_idx), .act_flat(act_flat), .seg_out(seg_out)
);

// File: tb/gs_seg_modulator_test.sv
module gs_seg_modulator_test;
   localparam int CLK_PERIOD = 10;
   localparam int NSEG   = 128;
   localparam int SLOTS  = 8;
   localparam int MAXL   = 32;
   localparam int LW     = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [2*NSEG-1:0] pix_row;
   logic              lvl_wr_en;
   logic [1:0]        lvl_wr_sel;
   logic [LW-1:0]     lvl_wr_data;
   logic              frame_start;
   logic [1:0]        frame_phase;
   logic              line_start;
   logic              slot_step;
   logic              fr;
   logic              disp_off;
   logic [NSEG-1:0]   seg_out;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;
   int  pend_m [4];
   int  act_m  [4];
   int  codes  [NSEG];

   always #(CLK_PERIOD/2) clk = ~clk;

   gs_seg_modulator #(.NSEG(NSEG)) uut (
      .clk(clk), .rst_n(rst_n), .pix_row(pix_row),
      .lvl_wr_en(lvl_wr_en), .lvl_wr_sel(lvl_wr_sel), .lvl_wr_data(lvl_wr_data),
      .frame_start(frame_start), .frame_phase(frame_phase),
      .line_start(line_start), .slot_step(slot_step),
      .fr(fr), .disp_off(disp_off), .seg_out(seg_out)
   );

   function automatic bit exp_on(int lvl, int k, int s);
      return (k*SLOTS + s) < lvl;
   endfunction

   function automatic logic [NSEG-1:0] exp_vec(int k, int s, bit f, bit off);
      logic [NSEG-1:0] v;
      for (int i = 0; i < NSEG; i++)
         v[i] = (exp_on(act_m[codes[i]], k, s) && !off) ^ f;
      return v;
   endfunction

   task automatic check_vec(string r, logic [NSEG-1:0] act, logic [NSEG-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic check_int(string r, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic load_codes(bit random_codes, int fixed_code);
      for (int i = 0; i < NSEG; i++) begin
         codes[i] = random_codes ? int'($urandom_range(3)) : fixed_code;
         pix_row[2*i +: 2] = 2'(codes[i]);
      end
   endtask

   task automatic write_lvl(int sel, int val);
      lvl_wr_en   = 1'b1;
      lvl_wr_sel  = 2'(sel);
      lvl_wr_data = LW'(val);
      @(negedge clk);
      lvl_wr_en   = 1'b0;
      pend_m[sel] = (val > MAXL) ? MAXL : val;
   endtask

   // one common line: restart, then eight slot steps, each result checked
   task automatic run_line(int k, bit f, bit off, bit fs, string r, output int tally0);
      frame_phase = 2'(k);
      fr          = f;
      disp_off    = off;
      line_start  = 1'b1;
      frame_start = fs;
      @(negedge clk);
      if (fs) act_m = pend_m;
      line_start  = 1'b0;
      frame_start = 1'b0;
      tally0 = 0;
      for (int s = 0; s < SLOTS; s++) begin
         slot_step = 1'b1;
         @(negedge clk);
         check_vec(r, seg_out, exp_vec(k, s, f, off));
         tally0 += int'(seg_out[0] ^ f);
      end
      slot_step = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int t;
      int total;
      int lim;
      logic [NSEG-1:0] prev;
      void'($urandom(32'd4242));
      rst_n = 1'b0; lvl_wr_en = 0; lvl_wr_sel = 0; lvl_wr_data = 0;
      frame_start = 0; frame_phase = 0; line_start = 0; slot_step = 0;
      fr = 0; disp_off = 0; pix_row = '0;
      pend_m = '{0, 11, 21, 32};
      act_m  = pend_m;
      repeat (3) @(negedge clk);
      check_vec("R1", seg_out, '0);
      rst_n = 1'b1;

      // R1: reset defaults seen through the output, no frame boundary yet
      load_codes(1, 0);
      run_line(1, 0, 0, 0, "R1", t);
      run_line(2, 1, 0, 0, "R1", t);

      // R2 / R3 / R4 / R5 / R7: full level sweep through code 1
      for (int L = 0; L <= MAXL + 1; L++) begin
         load_codes(1, 0);
         codes[0] = 1;
         pix_row[1:0] = 2'd1;
         write_lvl(1, L);
         if ($urandom_range(1) == 1) write_lvl(int'($urandom_range(3)) == 1 ? 2 : 3,
                                               int'($urandom_range(MAXL)));
         total = 0;
         for (int k = 0; k < 4; k++) begin
            run_line(k, bit'($urandom_range(1)), 0, k == 0, "R2_R7", t);
            total += t;
         end
         lim = (L > MAXL) ? MAXL : L;
         if (L > MAXL)       check_int("R5", total, lim);
         else if (L == MAXL) check_int("R4", total, lim);
         else                check_int("R3", total, lim);
      end

      // R6: a write is invisible until the frame boundary
      load_codes(0, 2);
      write_lvl(2, 13);
      run_line(1, 0, 0, 0, "R6", t);
      check_int("R6", t, exp_on(act_m[2], 1, 0) + 0 == 0 ? 0 : t);
      run_line(1, 0, 0, 1, "R6", t);
      check_int("R6", t, 5);

      // R8: display off with both polarities
      load_codes(1, 0);
      run_line(0, 0, 1, 0, "R8", t);
      run_line(3, 1, 1, 0, "R8", t);

      // R9: line start beats a simultaneous step, then saturation
      write_lvl(1, 7);
      load_codes(0, 1);
      line_start = 1'b1; slot_step = 1'b1; frame_start = 1'b1;
      frame_phase = 2'd0; fr = 1'b0; disp_off = 1'b0;
      @(negedge clk);
      act_m = pend_m;
      line_start = 1'b0; frame_start = 1'b0;
      for (int s = 0; s < 11; s++) begin
         @(negedge clk);
         check_vec("R9", seg_out, exp_vec(0, (s > SLOTS-1) ? SLOTS-1 : s, 0, 0));
      end
      slot_step = 1'b0;

      // R10: output changes only at the clock edge
      disp_off = 1'b1; fr = 1'b0;
      @(negedge clk);
      prev = seg_out;
      check_vec("R10", prev, '0);
      fr = 1'b1;
      #1;
      check_vec("R10", seg_out, prev);
      @(negedge clk);
      check_vec("R10", seg_out, '1);
      disp_off = 1'b0; fr = 1'b0;

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule